// File: doc/BRIEF.md
# Bit-Sliced Multi-Operation Register

This block is a register of parameterised width that can rewrite itself with one of three results: its own value moved one place toward the most significant end, its value exclusive-ORed with an operand, or the sum of its value and the operand. The register is made of identical one-bit slices. Each slice holds a flip-flop fed by a small combinational cell. That cell sees its own stored bit, the stored bit of the slice below it, the operand bit and an incoming carry. It produces the next value of the bit and passes a carry up to the next slice.

Three operation strobes choose the result. The OR of the strobes is the load enable. In a cycle where no strobe is raised, the register keeps its value. A synchronous active-high reset clears it to zero.

Top module: `opreg`

## Requirements
- R1: On a clock edge with `rst` high, `acc` becomes all zeros, whatever the strobes are.
- R2: On a clock edge where `do_shl`, `do_xor` and `do_add` are all low and `rst` is low, `acc` keeps its value.
- R3: When `do_shl` alone is high, `acc` becomes its old value shifted left by one. Bit i takes old bit i-1, bit 0 takes 0, and the old most significant bit is lost.
- R4: When `do_xor` alone is high, `acc` becomes old `acc` XOR `opb`.
- R5: When `do_add` alone is high, `acc` becomes (old `acc` + `opb`) modulo 2^W. The carry into bit 0 is 0 and the carry out of the top bit is dropped.
- R6: When more than one strobe is high, add takes priority over XOR, and XOR takes priority over shift.
- R7: Every operation takes effect on the first clock edge after the strobe is set. The new `acc` is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| do_shl | input | 1 | Strobe: shift left by one |
| do_xor | input | 1 | Strobe: XOR with operand |
| do_add | input | 1 | Strobe: add operand |
| opb | input | W | Operand |
| acc | output | W | Register contents |

## Verification
A broken slice shows up on `acc` on the very next edge after an operation. If a slice is stuck or has a wrong cell function, one bit position is wrong. If the carry link between slices is broken, the error shows only on an add where the operands make a carry cross that link. Sums with long carry runs, such as all ones plus one, therefore get their own checks. Because the register feeds back on itself, a wrong bit also corrupts every later result until the next reset. So each vector loads a known value first.

// File: rtl/opreg.sv
module opreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         do_shl,
  input  logic         do_xor,
  input  logic         do_add,
  input  logic [W-1:0] opb,
  output logic [W-1:0] acc
);

  logic         ld;
  logic [W:0]   cy;
  logic [W-1:0] nxt;

  assign ld    = do_shl | do_xor | do_add;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic below, s, cout;
    if (i == 0) begin : g_lsb
      assign below = 1'b0;
    end else begin : g_up
      assign below = acc[i-1];
    end
    assign s       = acc[i] ^ opb[i] ^ cy[i];
    assign cout    = (acc[i] & opb[i]) | (cy[i] & (acc[i] ^ opb[i]));
    assign cy[i+1] = cout;
    assign nxt[i]  = do_add ? s : do_xor ? (acc[i] ^ opb[i]) : below;

    always_ff @(posedge clk) begin
      if (rst)     acc[i] <= 1'b0;
      else if (ld) acc[i] <= nxt[i];
    end
  end

  // R1
  clear_chk: assert property (@(posedge clk) rst |=> acc == '0);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(do_shl | do_xor | do_add) |=> $stable(acc));
  // R3
  shl_chk: assert property (@(posedge clk) disable iff (rst)
    (do_shl & !do_xor & !do_add) |=> acc == ($past(acc) << 1));
  // R4
  xor_chk: assert property (@(posedge clk) disable iff (rst)
    (do_xor & !do_add) |=> acc == ($past(acc) ^ $past(opb)));
  // R5
  add_chk: assert property (@(posedge clk) disable iff (rst)
    do_add |=> acc == W'($past(acc) + $past(opb)));

endmodule

// File: tb/opreg_bench.sv
module opreg_bench;
  localparam int W = 4;
  localparam int NV = 12;
  // each entry: {start, operand, op(0 shl,1 xor,2 add), expected}
  localparam logic [13:0] VEC [NV] = '{
    {4'h5, 4'h0, 2'd0, 4'hA}, {4'h8, 4'h0, 2'd0, 4'h0},
    {4'hF, 4'h0, 2'd0, 4'hE}, {4'hC, 4'hA, 2'd1, 4'h6},
    {4'hF, 4'hF, 2'd1, 4'h0}, {4'h0, 4'h9, 2'd1, 4'h9},
    {4'h3, 4'h4, 2'd2, 4'h7}, {4'hF, 4'h1, 2'd2, 4'h0},
    {4'h7, 4'h1, 2'd2, 4'h8}, {4'h9, 4'h9, 2'd2, 4'h2},
    {4'h0, 4'h0, 2'd2, 4'h0}, {4'hE, 4'hF, 2'd2, 4'hD}
  };

  logic clk = 0, rst = 1, do_shl = 0, do_xor = 0, do_add = 0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] acc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  opreg #(.W(W)) u_opreg (.clk, .rst, .do_shl, .do_xor, .do_add, .opb, .acc);

  task automatic chk(input string req, input logic [W-1:0] exp);
    checks++;
    if (acc !== exp) begin
      errors++;
      $display("FAIL %s: acc=%h expected=%h", req, acc, exp);
    end
  endtask

  task automatic step(input logic s, x, a, input logic [W-1:0] b);
    do_shl = s; do_xor = x; do_add = a; opb = b;
    @(posedge clk); #1;
    do_shl = 0; do_xor = 0; do_add = 0;
  endtask

  task automatic load(input logic [W-1:0] v);
    rst = 1; @(posedge clk); #1; rst = 0;
    step(0, 0, 1, v);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: acc=%h expected=done", acc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] m, n;
    @(posedge clk); #1; rst = 0;
    step(0, 0, 1, 4'hB);
    rst = 1; do_add = 1; opb = 4'h3; @(posedge clk); #1; rst = 0; do_add = 0;
    chk("R1", 4'h0);

    for (int k = 0; k < NV; k++) begin
      load(VEC[k][13:10]);
      step(VEC[k][5:4] == 0, VEC[k][5:4] == 1, VEC[k][5:4] == 2, VEC[k][9:6]);
      chk(VEC[k][5:4] == 0 ? "R3" : VEC[k][5:4] == 1 ? "R4" : "R5 R7", VEC[k][3:0]);
    end

    load(4'h6); opb = 4'h9;
    repeat (3) @(posedge clk); #1;
    chk("R2", 4'h6);

    load(4'h3); step(1, 1, 1, 4'h5); chk("R6 add wins", 4'h8);
    load(4'h3); step(1, 1, 0, 4'h5); chk("R6 xor wins", 4'h6);

    for (int k = 0; k < 40; k++) begin
      m = W'($urandom); n = W'($urandom);
      load(m); step(0, 0, 1, n); chk("R5", W'(m + n));
      load(m); step(0, 1, 0, n); chk("R4", m ^ n);
      load(m); step(1, 0, 0, n); chk("R3", W'(m << 1));
    end

    load(4'h1); step(1, 0, 0, 0); step(1, 0, 0, 0); step(0, 0, 1, 4'h2);
    chk("R7", 4'h6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule